// File: doc/BRIEF.md
# Floating-Point Coprocessor System Register Read Port

This block carries out the "move from system register" operation of a floating-point coprocessor. The issue logic presents a 4-bit register selector, a 4-bit destination index and three qualifiers: the condition outcome, the current privilege level and the coprocessor enable bit. The block sees the live values of five coprocessor system registers: identification, status/control, two media feature words and exception control. It resolves access permission first. A faulting access raises an undefined-instruction pulse in the cycle after start. A legal access raises a serialize request and waits for the floating-point pipeline to report idle. For status/control it also waits for pending floating-point exceptions to clear. It then captures the register and completes.

A completed read takes one of two forms. It is either a general-register write-back request carrying the index and data, or, for status/control with destination 15, an update of the integer N/Z/C/V flags. When the condition check fails, the operation does nothing. Selector codes that have no register in this block fault, so the behaviour is always defined.

Top module: `fpsr_read_port`

## Requirements
- R1: Selector 4'b0000 returns the identification word, 4'b0001 status/control, 4'b0110 media feature word 1, 4'b0111 media feature word 0 and 4'b1000 exception control. The value is presented on `wb_data_o` with `wb_en_o` high and `wb_idx_o` equal to the destination index.
- R2: Status/control read with destination 4'b1111: `flags_en_o` pulses and `flags_o` takes status bits [31:28] in the order N,Z,C,V (bit 3 of `flags_o` is N). `wb_en_o` stays low.
- R3: A status/control read with `cp_en_i` low raises `undef_o` in the cycle after start and never raises `sync_req_o`. With `cp_en_i` high it completes whatever the privilege level.
- R4: Reads of any selector other than status/control raise `undef_o` in the cycle after start when `priv_i` is low. When `priv_i` is high they complete even with `cp_en_i` low.
- R5: Selectors 4'b0010 to 4'b0101 and 4'b1001 to 4'b1111, and destination 4'b1111 with any selector other than status/control, raise `undef_o` and produce no write-back.
- R6: A start with `cond_i` low causes no write-back, no flag update, no exception, no serialize request and no busy.
- R7: After a legal start, `sync_req_o` and `busy_o` are high from the next cycle until `pipe_idle_i` is sampled high. In the cycle after that sampling edge, `done_o` pulses for one cycle together with the write-back or flag result, taken from the register value at that edge.
- R8: A status/control read also waits for `exc_clear_i` high at the same edge as `pipe_idle_i`. Other reads ignore `exc_clear_i`.
- R9: A start asserted while `busy_o` is high is ignored. The read in progress completes with its own selector and destination, and no second completion follows.
- R10: Under synchronous reset every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Operation issue strobe |
| cond_i | input | 1 | Condition check passed |
| priv_i | input | 1 | Processor in a privileged mode |
| cp_en_i | input | 1 | Coprocessor enable bit |
| sel_i | input | 4 | System register selector |
| dest_i | input | 4 | Destination register index |
| id_reg_i | input | DATA_W | Identification register value |
| stat_reg_i | input | DATA_W | Status/control register value |
| feat1_reg_i | input | DATA_W | Media feature word 1 |
| feat0_reg_i | input | DATA_W | Media feature word 0 |
| exc_reg_i | input | DATA_W | Exception control register value |
| pipe_idle_i | input | 1 | Floating-point pipeline drained |
| exc_clear_i | input | 1 | No pending floating-point exception |
| sync_req_o | output | 1 | Serialize request |
| busy_o | output | 1 | Read in progress |
| done_o | output | 1 | Completion pulse |
| undef_o | output | 1 | Undefined-instruction pulse |
| wb_en_o | output | 1 | General register write-back request |
| wb_idx_o | output | 4 | Write-back destination index |
| wb_data_o | output | DATA_W | Write-back data |
| flags_en_o | output | 1 | Integer flag update request |
| flags_o | output | 4 | N,Z,C,V value (N in bit 3) |

## Verification
Each of the five selectors is read with a distinct register value. A wrong decode therefore shows up as a wrong data word, not just a missing pulse. The permission checks sweep privilege against enable for status/control and for the other registers, so a fault tied to the wrong qualifier is caught. Reserved selectors and destination 15 on a non-status register are also probed. Held-off idle and exception-clear inputs separate the two wait conditions. A start issued during a wait shows whether the selector and destination captured at start are protected.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
  localparam int SEL_W = 4;
  localparam int IDX_W = 4;
  localparam int FLAG_W = 4;
  localparam logic [SEL_W-1:0] SEL_ID    = 4'h0;
  localparam logic [SEL_W-1:0] SEL_STAT  = 4'h1;
  localparam logic [SEL_W-1:0] SEL_FEAT1 = 4'h6;
  localparam logic [SEL_W-1:0] SEL_FEAT0 = 4'h7;
  localparam logic [SEL_W-1:0] SEL_EXC   = 4'h8;
  localparam logic [IDX_W-1:0] DEST_FLAGS = 4'hF;
  typedef enum logic {ST_IDLE, ST_WAIT} state_t;
endpackage

// File: rtl/fpsr_access_check.sv
module fpsr_access_check
  import fpsr_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  input  logic [IDX_W-1:0] dest,
  input  logic             priv,
  input  logic             cp_en,
  output logic             fault,
  output logic             is_stat,
  output logic             to_flags
);
  logic known;
  logic dest_is_f;

  always_comb begin
    is_stat   = (sel == SEL_STAT);
    dest_is_f = (dest == DEST_FLAGS);
    known     = (sel == SEL_ID) || (sel == SEL_FEAT1) ||
                (sel == SEL_FEAT0) || (sel == SEL_EXC);
    to_flags  = is_stat && dest_is_f;
    if (is_stat) fault = !cp_en;
    else         fault = !known || !priv || dest_is_f;
  end
endmodule

// File: rtl/fpsr_src_mux.sv
module fpsr_src_mux
  import fpsr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] id_reg,
  input  logic [DATA_W-1:0] stat_reg,
  input  logic [DATA_W-1:0] feat1_reg,
  input  logic [DATA_W-1:0] feat0_reg,
  input  logic [DATA_W-1:0] exc_reg,
  output logic [DATA_W-1:0] data
);
  always_comb begin
    unique case (sel)
      SEL_ID:    data = id_reg;
      SEL_STAT:  data = stat_reg;
      SEL_FEAT1: data = feat1_reg;
      SEL_FEAT0: data = feat0_reg;
      SEL_EXC:   data = exc_reg;
      default:   data = '0;
    endcase
  end
endmodule

// File: rtl/fpsr_ctrl.sv
module fpsr_ctrl
  import fpsr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              cond,
  input  logic              fault,
  input  logic              is_stat,
  input  logic              to_flags,
  input  logic [SEL_W-1:0]  sel_in,
  input  logic [IDX_W-1:0]  dest_in,
  input  logic [DATA_W-1:0] src_data,
  input  logic [DATA_W-1:0] stat_reg,
  input  logic              pipe_idle,
  input  logic              exc_clear,
  output logic [SEL_W-1:0]  sel_q,
  output logic              sync_req,
  output logic              busy,
  output logic              done,
  output logic              undef,
  output logic              wb_en,
  output logic [IDX_W-1:0]  wb_idx,
  output logic [DATA_W-1:0] wb_data,
  output logic              flags_en,
  output logic [FLAG_W-1:0] flags
);
  state_t           state;
  logic [IDX_W-1:0] dest_q;
  logic             stat_q;
  logic             flags_q;
  logic             ready;

  assign ready    = pipe_idle && (!stat_q || exc_clear);
  assign busy     = (state == ST_WAIT);
  assign sync_req = (state == ST_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      sel_q    <= '0;
      dest_q   <= '0;
      stat_q   <= 1'b0;
      flags_q  <= 1'b0;
      done     <= 1'b0;
      undef    <= 1'b0;
      wb_en    <= 1'b0;
      wb_idx   <= '0;
      wb_data  <= '0;
      flags_en <= 1'b0;
      flags    <= '0;
    end else begin
      done     <= 1'b0;
      undef    <= 1'b0;
      wb_en    <= 1'b0;
      flags_en <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start && cond) begin
            if (fault) begin
              undef <= 1'b1;
            end else begin
              state   <= ST_WAIT;
              sel_q   <= sel_in;
              dest_q  <= dest_in;
              stat_q  <= is_stat;
              flags_q <= to_flags;
            end
          end
        end
        ST_WAIT: begin
          if (ready) begin
            state <= ST_IDLE;
            done  <= 1'b1;
            if (flags_q) begin
              flags_en <= 1'b1;
              flags    <= stat_reg[DATA_W-1 -: FLAG_W];
            end else begin
              wb_en   <= 1'b1;
              wb_idx  <= dest_q;
              wb_data <= src_data;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fpsr_read_port.sv
module fpsr_read_port
  import fpsr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              cond_i,
  input  logic              priv_i,
  input  logic              cp_en_i,
  input  logic [3:0]        sel_i,
  input  logic [3:0]        dest_i,
  input  logic [DATA_W-1:0] id_reg_i,
  input  logic [DATA_W-1:0] stat_reg_i,
  input  logic [DATA_W-1:0] feat1_reg_i,
  input  logic [DATA_W-1:0] feat0_reg_i,
  input  logic [DATA_W-1:0] exc_reg_i,
  input  logic              pipe_idle_i,
  input  logic              exc_clear_i,
  output logic              sync_req_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              undef_o,
  output logic              wb_en_o,
  output logic [3:0]        wb_idx_o,
  output logic [DATA_W-1:0] wb_data_o,
  output logic              flags_en_o,
  output logic [3:0]        flags_o
);
  logic              fault, is_stat, to_flags;
  logic [SEL_W-1:0]  sel_q;
  logic [DATA_W-1:0] src_data;

  fpsr_access_check u_check (
    .sel(sel_i), .dest(dest_i), .priv(priv_i), .cp_en(cp_en_i),
    .fault(fault), .is_stat(is_stat), .to_flags(to_flags)
  );

  fpsr_src_mux #(.DATA_W(DATA_W)) u_mux (
    .sel(sel_q), .id_reg(id_reg_i), .stat_reg(stat_reg_i),
    .feat1_reg(feat1_reg_i), .feat0_reg(feat0_reg_i), .exc_reg(exc_reg_i),
    .data(src_data)
  );

  fpsr_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start_i), .cond(cond_i), .fault(fault),
    .is_stat(is_stat), .to_flags(to_flags), .sel_in(sel_i), .dest_in(dest_i),
    .src_data(src_data), .stat_reg(stat_reg_i), .pipe_idle(pipe_idle_i),
    .exc_clear(exc_clear_i), .sel_q(sel_q), .sync_req(sync_req_o),
    .busy(busy_o), .done(done_o), .undef(undef_o), .wb_en(wb_en_o),
    .wb_idx(wb_idx_o), .wb_data(wb_data_o), .flags_en(flags_en_o),
    .flags(flags_o)
  );
endmodule

// File: rtl/fpsr_read_port_chk.sv
module fpsr_read_port_chk (
  input logic       clk,
  input logic       rst,
  input logic       start_i,
  input logic       cond_i,
  input logic       priv_i,
  input logic       cp_en_i,
  input logic [3:0] sel_i,
  input logic [3:0] dest_i,
  input logic       pipe_idle_i,
  input logic       exc_clear_i,
  input logic       sync_req_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       undef_o,
  input logic       wb_en_o,
  input logic       flags_en_o
);
  logic accept;
  assign accept = start_i && !busy_o && cond_i;

  a_r3_stat_disabled_faults: assert property (@(posedge clk) disable iff (rst)
    accept && sel_i == 4'h1 && !cp_en_i |=> undef_o && !sync_req_o);

  a_r4_user_faults: assert property (@(posedge clk) disable iff (rst)
    accept && sel_i != 4'h1 && !priv_i |=> undef_o && !sync_req_o);

  a_r6_cond_fail_quiet: assert property (@(posedge clk) disable iff (rst)
    start_i && !busy_o && !cond_i |=> !undef_o && !sync_req_o && !done_o);

  a_r7_hold_until_idle: assert property (@(posedge clk) disable iff (rst)
    sync_req_o && !pipe_idle_i |=> sync_req_o && !done_o);

  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r2_one_result: assert property (@(posedge clk) disable iff (rst)
    !(wb_en_o && flags_en_o));

  a_r5_undef_no_result: assert property (@(posedge clk) disable iff (rst)
    undef_o |-> !done_o && !wb_en_o && !flags_en_o);
endmodule

bind fpsr_read_port fpsr_read_port_chk u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .cond_i(cond_i), .priv_i(priv_i),
  .cp_en_i(cp_en_i), .sel_i(sel_i), .dest_i(dest_i),
  .pipe_idle_i(pipe_idle_i), .exc_clear_i(exc_clear_i),
  .sync_req_o(sync_req_o), .busy_o(busy_o), .done_o(done_o),
  .undef_o(undef_o), .wb_en_o(wb_en_o), .flags_en_o(flags_en_o)
);

// File: tb/fpsr_read_port_bench.sv
module fpsr_read_port_bench;
  localparam int DW = 32;
  localparam logic [DW-1:0] V_ID = 32'h4101_2033, V_ST = 32'h9000_1234,
    V_F1 = 32'h1111_0111, V_F0 = 32'h1022_2222, V_EX = 32'h4000_0700;

  logic clk = 0, rst = 1, start = 0, cond = 1, priv = 1, cp_en = 1;
  logic [3:0] sel = 0, dest = 0;
  logic pipe_idle = 0, exc_clear = 1;
  logic sync_req, busy, done, undef, wb_en, flags_en;
  logic [3:0] wb_idx, flags;
  logic [DW-1:0] wb_data;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  fpsr_read_port #(.DATA_W(DW)) u_fpsr_read_port (
    .clk(clk), .rst(rst), .start_i(start), .cond_i(cond), .priv_i(priv),
    .cp_en_i(cp_en), .sel_i(sel), .dest_i(dest), .id_reg_i(V_ID),
    .stat_reg_i(V_ST), .feat1_reg_i(V_F1), .feat0_reg_i(V_F0),
    .exc_reg_i(V_EX), .pipe_idle_i(pipe_idle), .exc_clear_i(exc_clear),
    .sync_req_o(sync_req), .busy_o(busy), .done_o(done), .undef_o(undef),
    .wb_en_o(wb_en), .wb_idx_o(wb_idx), .wb_data_o(wb_data),
    .flags_en_o(flags_en), .flags_o(flags)
  );

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] s, input logic [3:0] d, input logic c,
                       input logic p, input logic e);
    @(negedge clk);
    sel = s; dest = d; cond = c; priv = p; cp_en = e; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic expect_fault(input string tag);
    chk(undef === 1'b1, {tag, " undef"}, DW'(undef), 1);
    chk(sync_req === 1'b0, {tag, " no sync"}, DW'(sync_req), 0);
    @(negedge clk);
    chk(undef === 1'b0 && wb_en === 1'b0 && done === 1'b0, {tag, " quiet after"},
        DW'({undef, wb_en, done}), 0);
  endtask

  task automatic finish_ok(input int waits, input logic [3:0] d,
                           input logic [DW-1:0] exp, input string tag);
    for (int i = 0; i < waits; i++) begin
      chk(sync_req === 1'b1 && busy === 1'b1 && done === 1'b0, {tag, " waiting"},
          DW'({sync_req, busy, done}), 3'b110);
      @(negedge clk);
    end
    pipe_idle = 1;
    @(negedge clk);
    pipe_idle = 0;
    chk(done === 1'b1 && wb_en === 1'b1 && flags_en === 1'b0, {tag, " completion"},
        DW'({done, wb_en, flags_en}), 3'b110);
    chk(wb_data === exp, {tag, " data"}, wb_data, exp);
    chk(wb_idx === d, {tag, " index"}, DW'(wb_idx), DW'(d));
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, {tag, " done single"}, DW'({done, busy}), 0);
  endtask

  task automatic t_reset;
    chk({sync_req, busy, done, undef, wb_en, flags_en, wb_idx, flags} === '0 &&
        wb_data === '0, "R10 reset outputs", DW'(busy), 0);
  endtask

  task automatic t_selectors;
    issue(4'h0, 4'h2, 1, 1, 1); finish_ok(2, 4'h2, V_ID, "R1/R7 id");
    issue(4'h1, 4'h3, 1, 1, 1); finish_ok(1, 4'h3, V_ST, "R1 status");
    issue(4'h6, 4'h4, 1, 1, 1); finish_ok(3, 4'h4, V_F1, "R1 feat1");
    issue(4'h7, 4'h5, 1, 1, 1); finish_ok(0, 4'h5, V_F0, "R1 feat0");
    issue(4'h8, 4'hE, 1, 1, 1); finish_ok(1, 4'hE, V_EX, "R1 exc");
  endtask

  task automatic t_flags;
    issue(4'h1, 4'hF, 1, 0, 1);
    chk(sync_req === 1'b1, "R3 user status sync", DW'(sync_req), 1);
    pipe_idle = 1;
    @(negedge clk);
    pipe_idle = 0;
    chk(flags_en === 1'b1 && wb_en === 1'b0, "R2 flag update only",
        DW'({flags_en, wb_en}), 2'b10);
    chk(flags === 4'b1001, "R2 NZCV value", DW'(flags), 4'b1001);
  endtask

  task automatic t_stat_disabled;
    issue(4'h1, 4'h3, 1, 1, 0); expect_fault("R3 status enable clear");
  endtask

  task automatic t_priv;
    issue(4'h0, 4'h3, 1, 0, 1); expect_fault("R4 user id");
    issue(4'h8, 4'h3, 1, 0, 0); expect_fault("R4 user exc");
    issue(4'h8, 4'h6, 1, 1, 0); finish_ok(1, 4'h6, V_EX, "R4 priv disabled ok");
  endtask

  task automatic t_reserved;
    issue(4'h2, 4'h1, 1, 1, 1); expect_fault("R5 sel 2");
    issue(4'h5, 4'h1, 1, 1, 1); expect_fault("R5 sel 5");
    issue(4'h9, 4'h1, 1, 1, 1); expect_fault("R5 sel 9");
    issue(4'hF, 4'h1, 1, 1, 1); expect_fault("R5 sel F");
    issue(4'h6, 4'hF, 1, 1, 1); expect_fault("R5 dest 15 feat1");
  endtask

  task automatic t_cond_fail;
    issue(4'h0, 4'h1, 0, 1, 1);
    for (int i = 0; i < 3; i++) begin
      chk({undef, sync_req, busy, done, wb_en, flags_en} === '0, "R6 no effect",
          DW'({undef, sync_req, busy, done, wb_en, flags_en}), 0);
      @(negedge clk);
    end
    issue(4'hA, 4'hF, 0, 0, 0);
    chk({undef, sync_req, busy} === '0, "R6 no fault when cond fails",
        DW'({undef, sync_req, busy}), 0);
  endtask

  task automatic t_barrier;
    issue(4'h1, 4'h7, 1, 1, 1);
    exc_clear = 0; pipe_idle = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(sync_req === 1'b1 && done === 1'b0, "R8 status waits for exc clear",
          DW'({sync_req, done}), 2'b10);
    end
    exc_clear = 1;
    @(negedge clk);
    pipe_idle = 0;
    chk(done === 1'b1 && wb_data === V_ST, "R8 status completes", wb_data, V_ST);
    issue(4'h7, 4'h8, 1, 1, 1);
    exc_clear = 0; pipe_idle = 1;
    @(negedge clk);
    pipe_idle = 0; exc_clear = 1;
    chk(done === 1'b1 && wb_data === V_F0, "R8 other ignores exc clear", wb_data, V_F0);
  endtask

  task automatic t_busy;
    issue(4'h6, 4'h9, 1, 1, 1);
    sel = 4'h7; dest = 4'h5; start = 1;
    @(negedge clk);
    start = 0;
    pipe_idle = 1;
    @(negedge clk);
    pipe_idle = 0;
    chk(wb_data === V_F1, "R9 data from first start", wb_data, V_F1);
    chk(wb_idx === 4'h9, "R9 index from first start", DW'(wb_idx), 4'h9);
    @(negedge clk);
    chk(busy === 1'b0 && sync_req === 1'b0, "R9 second start dropped",
        DW'({busy, sync_req}), 0);
    @(negedge clk);
    chk(done === 1'b0, "R9 no second completion", DW'(done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 0;
    t_selectors();
    t_flags();
    t_stat_disabled();
    t_priv();
    t_reserved();
    t_cond_fail();
    t_barrier();
    t_busy();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule